// File: doc/BRIEF.md
# Register Pointer with Banded Auto-Increment

This block keeps the register index for a 13-entry register file that sits behind a serial bus target. The first byte after the address carries a setup byte. The bus engine passes that byte to this block with a one-cycle load strobe. The low nibble of the byte sets the starting register. The top three bits select how the pointer moves afterwards. Each time a data byte has been read or written, the engine pulses a byte-done strobe and the pointer advances.

In a band mode the pointer wraps inside a fixed range of registers:

- the whole file,
- the four brightness registers,
- the two group registers, or
- brightness plus group registers.

The block does not wrap linearly over the whole pointer space. It also raises a flag for pointer values the engine must not acknowledge. It exposes the active mode bits so that the register file can return them as read-only bits.

All pins are plain control strobes and levels. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. A strobe is taken in the cycle it is high. The outputs change on the following clock edge.

Top module: `regptr_autoinc`

## Requirements
- R1: After reset, `reg_ptr` is 0, `ai_mode` is 3'b000 and `ptr_valid` is 1.
- R2: A cycle with `ctrl_load` high sets `reg_ptr` to `ctrl_byte[3:0]` and `ai_mode` to `ctrl_byte[7:5]` on the next edge. `ctrl_byte[4]` has no effect. When both strobes are high, the load wins.
- R3: When `ai_mode[2]` is 0 (mode 000, and also the reserved modes 001, 010 and 011), `byte_done` leaves `reg_ptr` unchanged.
- R4: In mode 100, each `byte_done` adds one to the pointer, and the pointer goes from 0Ch to 00h.
- R5: In mode 101, the pointer goes from 05h back to 02h.
- R6: In mode 110, the pointer goes from 07h back to 06h.
- R7: In mode 111, the pointer goes from 07h back to 02h.
- R8: In a band mode, a pointer that is not at the band's top adds one. From 0Ch or above it goes to 00h. Loading E8h therefore gives 08h..0Ch, then 00h..07h, then 02h..07h repeated.
- R9: `ptr_valid` is 0 exactly when `reg_ptr` is 0Dh, 0Eh or 0Fh.
- R10: In a cycle with neither strobe high, `reg_ptr` and `ai_mode` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_load | input | 1 | Take the setup byte this cycle |
| ctrl_byte | input | 8 | Setup byte: [7:5] mode, [4] pad, [3:0] start register |
| byte_done | input | 1 | One data byte has finished; advance the pointer |
| reg_ptr | output | 4 | Current register index |
| ptr_valid | output | 1 | Index names a real register (00h..0Ch) |
| ai_mode | output | 3 | Active auto-increment bits, for read-back |

## Verification
Each band mode is stepped well past its top. This separates a correct wrap point and wrap target from a plain modulo-16 counter. Starts below the band, above the band and in the reserved range separate the linear approach from the 0Ch-to-00h fold. The E8h sequence is checked value by value. Loads with bit 4 set, loads that coincide with byte-done, and idle gaps show which input wins and that nothing drifts while the strobes are low.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  localparam int PTR_W = 4;
  localparam int AI_W  = 3;

  typedef enum logic [AI_W-1:0] {
    AI_FIXED  = 3'b000,
    AI_WHOLE  = 3'b100,
    AI_BRIGHT = 3'b101,
    AI_GROUP  = 3'b110,
    AI_BRGRP  = 3'b111
  } ai_mode_e;
endpackage

// File: rtl/regptr_band_decode.sv
module regptr_band_decode #(
  parameter int PTR_W    = 4,
  parameter int AI_W     = 3,
  parameter int LAST_REG = 12,
  parameter int BR_LO    = 2,
  parameter int BR_HI    = 5,
  parameter int GR_LO    = 6,
  parameter int GR_HI    = 7
) (
  input  logic [AI_W-1:0]  mode,
  output logic [PTR_W-1:0] band_lo,
  output logic [PTR_W-1:0] band_hi,
  output logic             step_en
);
  import regptr_pkg::*;

  always_comb begin
    step_en = 1'b1;
    band_lo = '0;
    band_hi = '0;
    case (mode)
      AI_WHOLE:  begin band_lo = '0;              band_hi = PTR_W'(LAST_REG); end
      AI_BRIGHT: begin band_lo = PTR_W'(BR_LO);   band_hi = PTR_W'(BR_HI);    end
      AI_GROUP:  begin band_lo = PTR_W'(GR_LO);   band_hi = PTR_W'(GR_HI);    end
      AI_BRGRP:  begin band_lo = PTR_W'(BR_LO);   band_hi = PTR_W'(GR_HI);    end
      default:   step_en = 1'b0;  // fixed pointer, reserved codes included
    endcase
  end
endmodule

// File: rtl/regptr_step.sv
module regptr_step #(
  parameter int PTR_W    = 4,
  parameter int LAST_REG = 12
) (
  input  logic [PTR_W-1:0] cur,
  input  logic [PTR_W-1:0] band_lo,
  input  logic [PTR_W-1:0] band_hi,
  input  logic             step_en,
  output logic [PTR_W-1:0] nxt
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_REG);

  always_comb begin
    if (!step_en)             nxt = cur;
    else if (cur == band_hi)  nxt = band_lo;
    else if (cur >= LAST_P)   nxt = '0;
    else                      nxt = cur + 1'b1;
  end
endmodule

// File: rtl/regptr_autoinc.sv
module regptr_autoinc #(
  parameter int PTR_W    = regptr_pkg::PTR_W,
  parameter int AI_W     = regptr_pkg::AI_W,
  parameter int LAST_REG = 12,
  parameter int BR_LO    = 2,
  parameter int BR_HI    = 5,
  parameter int GR_LO    = 6,
  parameter int GR_HI    = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_load,
  input  logic [AI_W+PTR_W:0]    ctrl_byte,
  input  logic                   byte_done,
  output logic [PTR_W-1:0]       reg_ptr,
  output logic                   ptr_valid,
  output logic [AI_W-1:0]        ai_mode
);
  localparam int CTRL_W = AI_W + 1 + PTR_W;
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(LAST_REG);

  logic [PTR_W-1:0] band_lo, band_hi, ptr_nxt;
  logic             step_en;
  logic             unused_pad;

  assign unused_pad = ctrl_byte[PTR_W];

  regptr_band_decode #(
    .PTR_W(PTR_W), .AI_W(AI_W), .LAST_REG(LAST_REG),
    .BR_LO(BR_LO), .BR_HI(BR_HI), .GR_LO(GR_LO), .GR_HI(GR_HI)
  ) u_band (
    .mode(ai_mode), .band_lo(band_lo), .band_hi(band_hi), .step_en(step_en)
  );

  regptr_step #(.PTR_W(PTR_W), .LAST_REG(LAST_REG)) u_step (
    .cur(reg_ptr), .band_lo(band_lo), .band_hi(band_hi),
    .step_en(step_en), .nxt(ptr_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_ptr <= '0;
      ai_mode <= '0;
    end else if (ctrl_load) begin
      reg_ptr <= ctrl_byte[PTR_W-1:0];
      ai_mode <= ctrl_byte[CTRL_W-1 -: AI_W];
    end else if (byte_done) begin
      reg_ptr <= ptr_nxt;
    end
  end

  assign ptr_valid = (reg_ptr <= LAST_P);
endmodule

// File: rtl/regptr_autoinc_chk.sv
module regptr_autoinc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_load,
  input logic [7:0] ctrl_byte,
  input logic       byte_done,
  input logic [3:0] reg_ptr,
  input logic       ptr_valid,
  input logic [2:0] ai_mode
);
  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> reg_ptr == $past(ctrl_byte[3:0])); // R2
  AST_LOAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_load |=> ai_mode == $past(ctrl_byte[7:5])); // R2
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_load && byte_done && !ai_mode[2]) |=> $stable(reg_ptr)); // R3
  AST_WHOLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_load && byte_done && ai_mode == 3'b100 && reg_ptr == 4'hC) |=> reg_ptr == 4'h0); // R4
  AST_BRIGHT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_load && byte_done && ai_mode == 3'b101 && reg_ptr == 4'h5) |=> reg_ptr == 4'h2); // R5
  AST_GROUP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_load && byte_done && ai_mode == 3'b110 && reg_ptr == 4'h7) |=> reg_ptr == 4'h6); // R6
  AST_BRGRP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_load && byte_done && ai_mode == 3'b111 && reg_ptr == 4'h7) |=> reg_ptr == 4'h2); // R7
  AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_load && ctrl_byte[3:0] > 4'hC) |=> !ptr_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_load && !byte_done) |=> ($stable(reg_ptr) && $stable(ai_mode))); // R10
endmodule

bind regptr_autoinc regptr_autoinc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_load(ctrl_load), .ctrl_byte(ctrl_byte),
  .byte_done(byte_done), .reg_ptr(reg_ptr), .ptr_valid(ptr_valid), .ai_mode(ai_mode)
);

// File: tb/regptr_autoinc_test.sv
module regptr_autoinc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_load = 1'b0;
  logic [7:0] ctrl_byte = 8'h00;
  logic       byte_done = 1'b0;
  logic [3:0] reg_ptr;
  logic       ptr_valid;
  logic [2:0] ai_mode;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model state
  int m_ptr = 0;
  int m_mode = 0;

  always #4 clk = ~clk;

  regptr_autoinc uut (
    .clk(clk), .rst_n(rst_n), .ctrl_load(ctrl_load), .ctrl_byte(ctrl_byte),
    .byte_done(byte_done), .reg_ptr(reg_ptr), .ptr_valid(ptr_valid), .ai_mode(ai_mode)
  );

  function automatic int model_next(int p, int m);
    int lo, hi;
    if (m < 4) return p;
    case (m % 4)
      0: begin lo = 0; hi = 12; end
      1: begin lo = 2; hi = 5;  end
      2: begin lo = 6; hi = 7;  end
      default: begin lo = 2; hi = 7; end
    endcase
    if (p == hi) return lo;
    if (p >= 12) return 0;
    return p + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr  <= 0;
      m_mode <= 0;
    end else if (ctrl_load) begin
      m_ptr  <= ctrl_byte % 16;
      m_mode <= ctrl_byte / 32;
    end else if (byte_done) begin
      m_ptr <= model_next(m_ptr, m_mode);
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare against the model every cycle, shortly after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(cur_req, int'(reg_ptr), m_ptr, "reg_ptr");
      check(cur_req, int'(ai_mode), m_mode, "ai_mode");
      check("R9", int'(ptr_valid), (m_ptr <= 12) ? 1 : 0, "ptr_valid");
    end
  end

  task automatic load(logic [7:0] b, string req);
    @(negedge clk);
    cur_req = req;
    ctrl_load = 1'b1; ctrl_byte = b; byte_done = 1'b0;
    @(negedge clk);
    ctrl_load = 1'b0;
  endtask

  task automatic steps(int n, string req);
    cur_req = req;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_done = 1'b1;
    end
    @(negedge clk);
    byte_done = 1'b0;
  endtask

  task automatic idle(int n, string req);
    cur_req = req;
    byte_done = 1'b0; ctrl_load = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_q[$];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", int'(reg_ptr), 0, "reg_ptr after reset");
    check("R1", int'(ai_mode), 0, "ai_mode after reset");
    check("R1", int'(ptr_valid), 1, "ptr_valid after reset");

    // R3 fixed and reserved modes
    load(8'h03, "R2"); steps(4, "R3");
    load(8'h27, "R2"); steps(3, "R3");
    load(8'h49, "R2"); steps(3, "R3");
    load(8'h6A, "R2"); steps(3, "R3");
    // R2 bit 4 ignored
    load(8'h94, "R2");
    check("R2", int'(reg_ptr), 4, "bit4 ignored ptr");
    check("R2", int'(ai_mode), 4, "bit4 ignored mode");
    // R4 whole file wrap
    load(8'h8A, "R2"); steps(6, "R4");
    // R5 brightness band
    load(8'hA3, "R2"); steps(7, "R5");
    // R6 group band
    load(8'hC6, "R2"); steps(5, "R6");
    // R7 brightness+group band
    load(8'hE5, "R2"); steps(9, "R7");
    // R8 starts outside band, reserved range
    load(8'hA7, "R2"); steps(12, "R8");
    load(8'hCE, "R2");
    check("R9", int'(ptr_valid), 0, "reserved 0Eh flagged");
    steps(10, "R8");
    load(8'h8D, "R2"); steps(4, "R8");

    // R8 explicit E8h sequence
    exp_q = '{8,9,10,11,12,0,1,2,3,4,5,6,7,2,3,4,5,6,7,2};
    load(8'hE8, "R8");
    foreach (exp_q[i]) begin
      check("R8", int'(reg_ptr), exp_q[i], "E8h sequence");
      @(negedge clk); byte_done = 1'b1;
      @(negedge clk); byte_done = 1'b0;
    end

    // R10 idle hold
    idle(5, "R10");
    check("R10", int'(reg_ptr), 3, "idle hold ptr");

    // R2 load wins over byte_done
    @(negedge clk);
    cur_req = "R2";
    ctrl_load = 1'b1; byte_done = 1'b1; ctrl_byte = 8'hA5;
    @(negedge clk);
    ctrl_load = 1'b0; byte_done = 1'b0;
    check("R2", int'(reg_ptr), 5, "load priority");
    steps(1, "R5");
    check("R5", int'(reg_ptr), 2, "05h wraps to 02h");

    idle(2, "R10");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule